// File: doc/BRIEF.md
# Periodic-Correction Clock Calibration Divider

This block turns a stream of oscillator enables, nominally 32,768 per second, into a one-clock tick once per second. It also keeps a minute position inside a repeating 64-minute correction cycle. The tick feeds a calendar and the minute count is brought out with it.

The rate is trimmed by a 5-bit magnitude and a sign bit. The trim is not a fractional divider. Instead, the first second of some minutes is made a fixed amount shorter or longer. A magnitude of N touches the first 2N minutes of each cycle, and only minutes 0 to 61 can ever be touched. A positive trim inserts one extra pulse at the divide-by-256 stage, so that second ends 256 oscillator cycles early. A negative trim stretches the first 256-stage period of that second by half, so the second ends 128 cycles late.

The magnitude and sign are sampled only at reset and at the boundary between two cycles. Each code step therefore gives the same fixed ppm shift over a whole cycle.

Top module: `rtc_cal_divider`

## Requirements
- R1: While reset is high and on the first cycle after it, `tick_o` is 0 and `minute_o` is 0.
- R2: A second that is not altered lasts exactly PRE_DIV*PRE_PER_SEC enabled cycles (32,768 by default). Clock cycles with `osc_en_i` low are not counted.
- R3: `tick_o` is high for exactly one clock. It is high on the clock after the edge that takes in the last enabled cycle of a second. It is never high after an edge at which `osc_en_i` was low.
- R4: `minute_o` runs 0 to CYCLE_MIN-1 (63). It advances on the tick that ends second SEC_PER_MIN-1 of a minute, and wraps from 63 to 0. It does not change at any other time.
- R5: With a latched magnitude N, second 0 of minutes 0 to 2N-1 is altered and no other second is. Minutes 62 and 63 are never altered.
- R6: With a latched sign of 1, each altered second is PRE_DIV (256) enabled cycles shorter than nominal.
- R7: With a latched sign of 0, each altered second is PRE_DIV/2 (128) enabled cycles longer than nominal.
- R8: `cal_mag_i` and `cal_pos_i` are sampled while reset is high, and on the tick that wraps `minute_o` from 63 to 0. Changes at any other time have no effect until the next sample.
- R9: One full cycle lasts 64*SEC_PER_MIN*nominal enabled cycles, adjusted by the trim. For sign 1 it is 2*N*PRE_DIV cycles shorter (125,829,120 - 512N by default). For sign 0 it is N*PRE_DIV cycles longer (+256N).
- R10: While `osc_en_i` is held low, no tick is produced and `minute_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| osc_en_i | input | 1 | One oscillator cycle has elapsed |
| cal_mag_i | input | CAL_W | Calibration magnitude, 0 to 31 |
| cal_pos_i | input | 1 | Calibration sign: 1 speeds up, 0 slows down |
| tick_o | output | 1 | One-clock pulse at the end of each second |
| minute_o | output | MIN_W | Minute position within the correction cycle |

## Verification
A wrong prescale or second-stage count shows as a wrong second length on the very next tick. The bench measures the enabled cycles between consecutive ticks and compares each one against the arithmetic expectation for that second and minute. A wrong minute or second index shows either as a trim landing on the wrong second or as a wrong `minute_o` value at the next tick. A latch of magnitude or sign at the wrong moment may only show at the cycle level, one full 64-minute cycle later. For that reason the inputs are changed in mid-cycle and every cycle total is compared as well.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // Kind of alteration applied to the current second.
  typedef enum logic [1:0] {
    ADJ_NONE     = 2'd0,
    ADJ_SHORTEN  = 2'd1,
    ADJ_LENGTHEN = 2'd2
  } adj_e;
endpackage

// File: rtl/rtc_cal_prescale.sv
// Divide-by-PRE_DIV stage; one period may be stretched to 1.5x.
module rtc_cal_prescale #(
  parameter int PRE_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic osc_en_i,
  input  logic stretch_i,
  output logic pulse_o
);
  localparam int LONG_DIV = PRE_DIV + PRE_DIV / 2;
  localparam int CNT_W    = $clog2(LONG_DIV);
  localparam logic [CNT_W-1:0] TERM_NORM = CNT_W'(PRE_DIV - 1);
  localparam logic [CNT_W-1:0] TERM_LONG = CNT_W'(LONG_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term    = stretch_i ? TERM_LONG : TERM_NORM;
  assign pulse_o = osc_en_i && (cnt_q == term);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (osc_en_i) begin
      if (pulse_o) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_cal_secstage.sv
// Counts prescale pulses to one second; a split pulse counts twice.
module rtc_cal_secstage #(
  parameter int PRE_PER_SEC = 128
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pulse_i,
  input  logic split_i,
  output logic sec_done_o,
  output logic first_o
);
  localparam int CNT_W = $clog2(PRE_PER_SEC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;

  assign nxt        = {1'b0, cnt_q} + (CNT_W+1)'(split_i ? 2 : 1);
  assign sec_done_o = pulse_i && (nxt >= (CNT_W+1)'(PRE_PER_SEC));
  assign first_o    = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (pulse_i) begin
      if (sec_done_o) cnt_q <= '0;
      else            cnt_q <= nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rtc_cal_sched.sv
// Second/minute position in the correction cycle and the trim latch.
module rtc_cal_sched
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64,
  parameter int ELIG_MIN    = 62,
  parameter int CAL_W       = 5,
  parameter int MIN_W       = $clog2(CYCLE_MIN)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sec_done_i,
  input  logic [CAL_W-1:0] cal_mag_i,
  input  logic             cal_pos_i,
  output adj_e             adj_o,
  output logic [MIN_W-1:0] minute_o,
  output logic [CAL_W-1:0] mag_o
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int CMP_W = ((MIN_W > CAL_W) ? MIN_W : CAL_W + 1) + 1;

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [CAL_W-1:0] mag_q;
  logic             pos_q;
  logic             last_sec, last_min, eligible;

  assign last_sec = (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign last_min = (min_q == MIN_W'(CYCLE_MIN - 1));
  assign eligible = (sec_q == '0)
                 && (CMP_W'(min_q) < CMP_W'({mag_q, 1'b0}))
                 && (CMP_W'(min_q) < CMP_W'(ELIG_MIN));

  always_comb begin
    if (!eligible)  adj_o = ADJ_NONE;
    else if (pos_q) adj_o = ADJ_SHORTEN;
    else            adj_o = ADJ_LENGTHEN;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q <= '0;
      min_q <= '0;
      mag_q <= cal_mag_i;
      pos_q <= cal_pos_i;
    end else if (sec_done_i) begin
      if (last_sec) begin
        sec_q <= '0;
        if (last_min) begin
          min_q <= '0;
          mag_q <= cal_mag_i;
          pos_q <= cal_pos_i;
        end else begin
          min_q <= min_q + 1'b1;
        end
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  assign minute_o = min_q;
  assign mag_o    = mag_q;
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
  import rtc_cal_pkg::*;
#(
  parameter int PRE_DIV     = 256,
  parameter int PRE_PER_SEC = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64,
  parameter int ELIG_MIN    = 62,
  parameter int CAL_W       = 5,
  parameter int MIN_W       = $clog2(CYCLE_MIN)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             osc_en_i,
  input  logic [CAL_W-1:0] cal_mag_i,
  input  logic             cal_pos_i,
  output logic             tick_o,
  output logic [MIN_W-1:0] minute_o
);
  logic             pre_pulse, sec_done, sec_first;
  logic             stretch, split;
  adj_e             adj;
  logic [CAL_W-1:0] mag_q;
  logic             tick_q;

  // Alterations act only on the first prescale period of the second.
  assign stretch = (adj == ADJ_LENGTHEN) && sec_first;
  assign split   = (adj == ADJ_SHORTEN)  && sec_first;

  rtc_cal_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .osc_en_i  (osc_en_i),
    .stretch_i (stretch),
    .pulse_o   (pre_pulse)
  );

  rtc_cal_secstage #(.PRE_PER_SEC(PRE_PER_SEC)) u_sec (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pulse_i    (pre_pulse),
    .split_i    (split),
    .sec_done_o (sec_done),
    .first_o    (sec_first)
  );

  rtc_cal_sched #(
    .SEC_PER_MIN (SEC_PER_MIN),
    .CYCLE_MIN   (CYCLE_MIN),
    .ELIG_MIN    (ELIG_MIN),
    .CAL_W       (CAL_W),
    .MIN_W       (MIN_W)
  ) u_sched (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sec_done_i (sec_done),
    .cal_mag_i  (cal_mag_i),
    .cal_pos_i  (cal_pos_i),
    .adj_o      (adj),
    .minute_o   (minute_o),
    .mag_o      (mag_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_q <= 1'b0;
    else       tick_q <= sec_done;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk #(
  parameter int CAL_W     = 5,
  parameter int MIN_W     = 6,
  parameter int CYCLE_MIN = 64
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             osc_en_i,
  input logic             tick_o,
  input logic [MIN_W-1:0] minute_o,
  input logic [CAL_W-1:0] mag_q
);
  assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  assert_no_tick_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !osc_en_i |=> !tick_o);

  assert_minute_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(minute_o) |-> (tick_o &&
      ((minute_o == MIN_W'($past(minute_o) + 1'b1)) ||
       ((minute_o == '0) && ($past(minute_o) == MIN_W'(CYCLE_MIN - 1))))));

  assert_cal_latch_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(mag_q) |-> (tick_o && (minute_o == '0)));
endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(
  .CAL_W     (CAL_W),
  .MIN_W     (MIN_W),
  .CYCLE_MIN (CYCLE_MIN)
) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .osc_en_i (osc_en_i),
  .tick_o   (tick_o),
  .minute_o (minute_o),
  .mag_q    (mag_q)
);

// File: tb/tb_rtc_cal_divider.sv
module tb_rtc_cal_divider;
  localparam int PD    = 4;
  localparam int PPS   = 4;
  localparam int SPM   = 2;
  localparam int CM    = 64;
  localparam int EM    = 62;
  localparam int CW    = 5;
  localparam int MW    = 6;
  localparam int BASE  = PD * PPS;
  localparam int NCFG  = 12;
  localparam int LIMIT = 60000;

  logic          clk = 1'b0;
  logic          rst, osc_en, cal_pos, tick;
  logic [CW-1:0] cal_mag;
  logic [MW-1:0] minute;

  always #10 clk = ~clk;

  rtc_cal_divider #(
    .PRE_DIV(PD), .PRE_PER_SEC(PPS), .SEC_PER_MIN(SPM),
    .CYCLE_MIN(CM), .ELIG_MIN(EM), .CAL_W(CW), .MIN_W(MW)
  ) dut (
    .clk_i(clk), .rst_i(rst), .osc_en_i(osc_en),
    .cal_mag_i(cal_mag), .cal_pos_i(cal_pos),
    .tick_o(tick), .minute_o(minute)
  );

  int errors = 0;
  int checks = 0;
  int cfg_mag [NCFG+1] = '{0, 0, 1, 1, 6, 6, 15, 31, 31, 30, 2, 17, 0};
  bit cfg_pos [NCFG+1] = '{1, 0, 1, 0, 1, 0, 1, 1, 0, 0, 1, 0, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int  clk_n, sec_len, cyc_tot, bsec, bmin, k, exp_len, exp_tot, stall_min;
    bit  en, en_prev, stall_tick;
    string tag;
    clk_n = 0; sec_len = 0; cyc_tot = 0; bsec = 0; bmin = 0; k = 0;
    en_prev = 1'b0; stall_tick = 1'b0; stall_min = 0;

    rst = 1'b1; osc_en = 1'b0;
    cal_mag = CW'(cfg_mag[0]); cal_pos = cfg_pos[0];
    repeat (4) @(negedge clk);
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(minute == '0, "R1 minute in reset", int'(minute), 0);

    rst = 1'b0;
    cal_mag = CW'(cfg_mag[1]); cal_pos = cfg_pos[1];

    while (k < NCFG && clk_n < LIMIT) begin
      en = !((clk_n % 5) == 4) && !(clk_n >= 5000 && clk_n < 5040);
      osc_en = en;
      if (en) sec_len++;
      en_prev = en;
      @(negedge clk);
      clk_n++;
      if (!en_prev && tick) begin
        check(1'b0, "R3 tick after idle edge", 1, 0);
      end
      if (clk_n > 5000 && clk_n <= 5040 && tick) stall_tick = 1'b1;
      if (tick) begin
        exp_len = BASE;
        tag = "R2 nominal second";
        if (bsec == 0 && bmin < 2 * cfg_mag[k] && bmin < EM) begin
          if (cfg_pos[k]) begin exp_len = BASE - PD;     tag = "R5 R6 shortened second"; end
          else            begin exp_len = BASE + PD / 2; tag = "R5 R7 lengthened second"; end
        end
        check(sec_len == exp_len, tag, sec_len, exp_len);
        cyc_tot += sec_len;
        sec_len = 0;
        bsec++;
        if (bsec == SPM) begin
          bsec = 0;
          bmin = (bmin + 1) % CM;
        end
        check(int'(minute) == bmin, "R4 minute position", int'(minute), bmin);
        if (bsec == 0 && bmin == 0) begin
          exp_tot = BASE * SPM * CM +
                    (cfg_pos[k] ? -2 * PD * cfg_mag[k] : PD * cfg_mag[k]);
          check(cyc_tot == exp_tot, "R8 R9 cycle total", cyc_tot, exp_tot);
          cyc_tot = 0;
          k++;
          if (k < NCFG) begin
            cal_mag = CW'(cfg_mag[k+1]);
            cal_pos = cfg_pos[k+1];
          end
        end
      end
      if (clk_n == 5000) stall_min = int'(minute);
      if (clk_n == 5040) begin
        check(!stall_tick, "R10 no tick while idle", int'(stall_tick), 0);
        check(int'(minute) == stall_min, "R10 minute held while idle", int'(minute), stall_min);
      end
    end

    if (k < NCFG) check(1'b0, "R3 watchdog expired", k, NCFG);

    osc_en = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(tick == 1'b0, "R1 tick after mid-run reset", int'(tick), 0);
    check(minute == '0, "R1 minute after mid-run reset", int'(minute), 0);
    rst = 1'b0;
    osc_en = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule